// File: doc/BRIEF.md
# Display Clock Divide-and-Squash Chain

This block makes a slow display-engine clock from a fast PLL clock. Everything runs in the fast clock domain, and no clock is ever gated. Three stages sit in series. A pre-divider drops its rate by one of four fixed ratios. A squasher then walks a programmable bit pattern and removes the cycles whose bit is zero. A final stage always halves the rate.

The result appears in two forms. One is a registered clock level that toggles on every cycle that survives the squasher. The other is a one-cycle enable pulse that marks each rising edge of that level.

The two front stages can each be bypassed, so the chain can also reproduce simpler arrangements. New settings are taken only when the pattern wraps, so a change never cuts a pattern period short. The output frequency is fast / ratio / (length / ones) / 2.

Top module: `dclk_chain`

## Requirements
- R1: `div_sel` picks the pre-divider ratio: 0 gives 1, 1 gives 1.5, 2 gives 2 and 3 gives 4.
- R2: At ratio 1.5 the pre-divider passes two of every three fast cycles. The spacing between passed cycles alternates between 1 and 2 fast cycles, so there are never two skipped cycles in a row.
- R3: The squasher uses one waveform bit for each cycle the pre-divider passes.
  - It starts at bit 0 and moves upward.
  - It returns to bit 0 after bit `len-1`.
  - A 1 bit keeps that cycle and a 0 bit removes it. Bits at or above the length are ignored.
- R4: `sq_len` values 1 to 16 set the waveform length. A value of 0, or anything above 16, is treated as 16.
- R5: `dclk_lvl` toggles one cycle after each cycle the squasher keeps. `dclk_ce` is high for exactly the cycles in which `dclk_lvl` has just turned 1.
- R6: In steady state, `dclk_lvl` toggles this many times over W fast cycles: W × ones / (len × ratio), where "ones" counts the 1 bits inside the length.
- R7: With `div_bypass` high, the pre-divider passes every cycle whatever `div_sel` says.
- R8: With `sq_bypass` high, the squasher passes every cycle whatever the waveform says.
- R9: A waveform with no 1 bit inside the active length behaves like a bypassed squasher.
- R10: The ratio, bypass, waveform and length inputs take effect only at a waveform wrap. While `rst_n` is low they are loaded directly.
- R11: When `rst_n` is low at a clock edge, the edge does three things:
  - It restarts the pre-divider count and the pattern index.
  - It clears `dclk_lvl` and `dclk_ce` to 0.
  - With ratio 1 and bit 0 set, `dclk_lvl` becomes 1, with `dclk_ce` high, at the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast PLL clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_sel | input | 2 | Pre-divider ratio code |
| div_bypass | input | 1 | Skip the pre-divider |
| sq_wave | input | WAVE_W (16) | Squash pattern, bit 0 used first |
| sq_len | input | LEN_W (5) | Pattern length |
| sq_bypass | input | 1 | Skip the squasher |
| dclk_ce | output | 1 | Pulse on each rising edge of the divided clock |
| dclk_lvl | output | 1 | Registered divided clock level |

## Verification
Output edges are counted over a window that holds a whole number of repeat periods. The pre-divider is tried at each of its four ratios with full, half, 12-of-16 and 15-of-16 patterns. This separates the ratio decoding from the squash counting.

A 5-bit pattern with junk above the length shows whether the index wraps at the length rather than at bit 15. A zero length checks that it is read as 16. An all-zero pattern and both bypass flags each pair a setting that would slow the chain with an expected count equal to a pass-through.

A configuration change made just after reset checks that the old rate holds until the wrap. Reset, asserted both at start and in mid-run, checks that the level clears and restarts at once.

// File: rtl/dclk_pkg.sv
// Package: shared encodings for the display clock chain.
// Assumes the ratio code is two bits wide; the order is part of the port contract.
package dclk_pkg;

    typedef enum logic [1:0] {
        DIV_R1   = 2'd0,
        DIV_R1P5 = 2'd1,
        DIV_R2   = 2'd2,
        DIV_R4   = 2'd3
    } div_sel_e;

    // Last count value of each ratio; the count wraps to 0 after it.
    function automatic logic [1:0] div_last(input div_sel_e sel);
        case (sel)
            DIV_R1:   return 2'd0;
            DIV_R1P5: return 2'd2;
            DIV_R2:   return 2'd1;
            default:  return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/dclk_prediv.sv
// Pre-divider: turns the free-running fast clock into a tick stream at
// 1/1, 2/3, 1/2 or 1/4 of the fast rate.
// Assumes: the select changes only in a cycle where tick_o is high, which
// holds because the parent loads settings at squasher wraps.
module dclk_prediv
    import dclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  div_sel_e sel,
    input  logic     bypass,
    output logic     tick_o
);

    logic [1:0] cnt_q;
    logic [1:0] last;

    assign last = div_last(sel);

    // Phase counter, restarted by reset and wrapped at the ratio's last value.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= 2'd0;
        else if (cnt_q >= last)  cnt_q <= 2'd0;
        else                     cnt_q <= cnt_q + 2'd1;
    end

    // Tick decode per ratio; 1.5 gives ticks at counts 0 and 1 of each three.
    always_comb begin
        if (bypass) begin
            tick_o = 1'b1;
        end else begin
            case (sel)
                DIV_R1:   tick_o = 1'b1;
                DIV_R1P5: tick_o = (cnt_q != 2'd2);
                DIV_R2:   tick_o = (cnt_q == 2'd1);
                default:  tick_o = (cnt_q == 2'd3);
            endcase
        end
    end

    // R2: at ratio 1.5 no two fast cycles in a row lack a tick.
    p_no_double_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == DIV_R1P5 && !bypass && !tick_o) |=> tick_o);

    // R1: at ratio 4 a tick is never followed directly by another.
    p_div4_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == DIV_R4 && !bypass && tick_o) |=> (!tick_o || sel != DIV_R4 || bypass));

endmodule

// File: rtl/dclk_squash.sv
// Squasher: steps through a waveform, one bit per input tick, and passes a
// tick only when its bit is 1. It flags the tick that consumes the last bit
// (the wrap), which the parent uses to load new settings.
// Assumes: wave and len change only in the cycle after a wrap.
module dclk_squash #(
    parameter int WAVE_W = 16,
    parameter int LEN_W  = $clog2(WAVE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_tick,
    input  logic [WAVE_W-1:0] wave,
    input  logic [LEN_W-1:0]  len,
    input  logic              bypass,
    output logic              out_tick,
    output logic              wrap_o
);

    localparam int IDX_W = (WAVE_W > 1) ? $clog2(WAVE_W) : 1;
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(WAVE_W);

    logic [LEN_W-1:0]  eff_len;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  last_idx;
    logic [WAVE_W-1:0] in_len_mask;
    logic              wave_empty;
    logic              keep;

    // Length clamp: 0 or anything past the waveform width means full width.
    always_comb begin
        if (len == '0 || len > FULL_LEN) eff_len = FULL_LEN;
        else                             eff_len = len;
    end

    assign last_idx = IDX_W'(eff_len - LEN_W'(1));

    // Mask marking the bits that lie inside the active length.
    for (genvar g = 0; g < WAVE_W; g++) begin : g_mask
        assign in_len_mask[g] = (LEN_W'(g) < eff_len);
    end

    assign wave_empty = ((wave & in_len_mask) == '0);
    assign keep       = bypass || wave_empty || wave[idx_q];
    assign out_tick   = in_tick && keep;
    assign wrap_o     = in_tick && (idx_q == last_idx);

    // Pattern index: advances per input tick, back to 0 after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n)          idx_q <= '0;
        else if (wrap_o)     idx_q <= '0;
        else if (in_tick)    idx_q <= idx_q + IDX_W'(1);
    end

    // R3: the index never leaves the active length.
    p_idx_in_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (LEN_W'(idx_q) < eff_len));

    // R3: the squasher can only remove ticks, never create them.
    p_no_extra_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick |-> in_tick);

    // R3: without an input tick the index holds.
    p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_tick |=> $stable(idx_q));

endmodule

// File: rtl/dclk_halve.sv
// Fixed halver: toggles the output level on every kept tick and raises a
// one-cycle enable in the cycle the level has just gone high.
// Assumes: in_tick is at most one pulse per fast cycle.
module dclk_halve (
    input  logic clk,
    input  logic rst_n,
    input  logic in_tick,
    output logic lvl_o,
    output logic ce_o
);

    // Level toggle and rising-edge enable, both cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_o <= 1'b0;
            ce_o  <= 1'b0;
        end else begin
            lvl_o <= lvl_o ^ in_tick;
            ce_o  <= in_tick && !lvl_o;
        end
    end

    // R5: the level only moves one cycle after a kept tick.
    p_toggle_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_tick |=> $stable(lvl_o));

    // R5: the enable marks exactly a fresh rise of the level.
    p_ce_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ce_o |-> (lvl_o && !$past(lvl_o)));

    // R11: a reset edge leaves both outputs low.
    p_reset_clear_r11: assert property (@(posedge clk)
        !rst_n |=> (!lvl_o && !ce_o));

endmodule

// File: rtl/dclk_chain.sv
// Top: pre-divider -> squasher -> halver, all in the fast clock domain.
// Holds an active copy of the settings, reloaded from the inputs during
// reset and at each squasher wrap, so a pattern period is never cut short.
// Assumes: the inputs are synchronous to clk.
module dclk_chain
    import dclk_pkg::*;
#(
    parameter int WAVE_W = 16,
    localparam int LEN_W = $clog2(WAVE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        div_sel,
    input  logic              div_bypass,
    input  logic [WAVE_W-1:0] sq_wave,
    input  logic [LEN_W-1:0]  sq_len,
    input  logic              sq_bypass,
    output logic              dclk_ce,
    output logic              dclk_lvl
);

    div_sel_e          act_sel;
    logic              act_div_byp;
    logic [WAVE_W-1:0] act_wave;
    logic [LEN_W-1:0]  act_len;
    logic              act_sq_byp;

    logic pre_tick;
    logic sq_tick;
    logic sq_wrap;

    // Active settings: loaded in reset and at every pattern wrap only.
    always_ff @(posedge clk) begin
        if (!rst_n || sq_wrap) begin
            act_sel     <= div_sel_e'(div_sel);
            act_div_byp <= div_bypass;
            act_wave    <= sq_wave;
            act_len     <= sq_len;
            act_sq_byp  <= sq_bypass;
        end
    end

    dclk_prediv u_prediv (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (act_sel),
        .bypass (act_div_byp),
        .tick_o (pre_tick)
    );

    dclk_squash #(
        .WAVE_W (WAVE_W),
        .LEN_W  (LEN_W)
    ) u_squash (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_tick  (pre_tick),
        .wave     (act_wave),
        .len      (act_len),
        .bypass   (act_sq_byp),
        .out_tick (sq_tick),
        .wrap_o   (sq_wrap)
    );

    dclk_halve u_halve (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_tick (sq_tick),
        .lvl_o   (dclk_lvl),
        .ce_o    (dclk_ce)
    );

    // R10: between wraps the active settings hold still.
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sq_wrap |=> ($stable(act_wave) && $stable(act_len) && $stable(act_sel)
                      && $stable(act_div_byp) && $stable(act_sq_byp)));

    // R10: a wrap can only happen on a pre-divider tick.
    p_wrap_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sq_wrap |-> pre_tick);

endmodule

// File: tb/dclk_chain_tb.sv
module dclk_chain_tb;

    localparam int WAVE_W = 16;
    localparam int LEN_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        div_sel = 2'd0;
    logic              div_bypass = 1'b0;
    logic [WAVE_W-1:0] sq_wave = '1;
    logic [LEN_W-1:0]  sq_len = 5'd16;
    logic              sq_bypass = 1'b0;
    logic              dclk_ce;
    logic              dclk_lvl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dclk_chain #(.WAVE_W(WAVE_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_sel    (div_sel),
        .div_bypass (div_bypass),
        .sq_wave    (sq_wave),
        .sq_len     (sq_len),
        .sq_bypass  (sq_bypass),
        .dclk_ce    (dclk_ce),
        .dclk_lvl   (dclk_lvl)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input logic [1:0] s, input logic db, input logic [15:0] w,
                           input logic [4:0] l, input logic sb);
        div_sel = s; div_bypass = db; sq_wave = w; sq_len = l; sq_bypass = sb;
    endtask

    function automatic int eff_len(input logic [4:0] l);
        return (l == 0 || l > 16) ? 16 : int'(l);
    endfunction

    // Expected toggles over the window from the rate formula (R6).
    function automatic int exp_toggles(input int win, input logic [1:0] s, input logic db,
                                       input logic [15:0] w, input logic [4:0] l, input logic sb);
        int len = eff_len(l);
        int ones = 0;
        int r2;
        for (int i = 0; i < len; i++) ones += w[i];
        if (sb || ones == 0) ones = len;
        if (db) r2 = 2;
        else case (s)
            2'd0: r2 = 2;
            2'd1: r2 = 3;
            2'd2: r2 = 4;
            default: r2 = 8;
        endcase
        return win * 2 * ones / (len * r2);
    endfunction

    // Count level changes and enable pulses over n fast cycles.
    task automatic count(input int n, output int tog, output int ces);
        logic prev = dclk_lvl;
        tog = 0; ces = 0;
        for (int i = 0; i < n; i++) begin
            tick(1);
            if (dclk_lvl != prev) tog++;
            if (dclk_ce) ces++;
            prev = dclk_lvl;
        end
    endtask

    task automatic rate_case(input string tag, input logic [1:0] s, input logic db,
                             input logic [15:0] w, input logic [4:0] l, input logic sb);
        int win = 240 * eff_len(l);
        int e = exp_toggles(win, s, db, w, l, sb);
        int tog, ces;
        set_cfg(s, db, w, l, sb);
        tick(200);
        count(win, tog, ces);
        check(tog == e, {tag, " toggles"}, tog, e);
        check(ces == e / 2, {tag, " enables (R5)"}, ces, e / 2);
    endtask

    task automatic test_reset_state();
        rst_n = 1'b0;
        set_cfg(2'd0, 1'b0, 16'hFFFF, 5'd16, 1'b0);
        tick(3);
        check(dclk_lvl == 1'b0, "R11 level in reset", dclk_lvl, 0);
        check(dclk_ce == 1'b0, "R11 enable in reset", dclk_ce, 0);
        rst_n = 1'b1;
        tick(1);
        check(dclk_lvl == 1'b1 && dclk_ce == 1'b1, "R11 first edge after release",
              {dclk_lvl, dclk_ce}, 3);
    endtask

    task automatic test_latch_at_wrap();
        int tog, ces;
        rst_n = 1'b0;
        set_cfg(2'd3, 1'b0, 16'hFFFF, 5'd16, 1'b0);
        tick(2);
        rst_n = 1'b1;
        tick(5);
        set_cfg(2'd3, 1'b0, 16'h8000, 5'd16, 1'b0);
        count(50, tog, ces);
        check(tog >= 11, "R10 old rate until wrap", tog, 11);
        tick(200);
        count(3840, tog, ces);
        check(tog == 60, "R10 new rate after wrap", tog, 60);
    endtask

    task automatic test_mid_reset();
        rst_n = 1'b0;
        tick(1);
        check(dclk_lvl == 1'b0 && dclk_ce == 1'b0, "R11 mid-run reset clears",
              {dclk_lvl, dclk_ce}, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        test_reset_state();
        rate_case("R1 R6 ratio1 full",            2'd0, 1'b0, 16'hFFFF, 5'd16, 1'b0);
        rate_case("R1 R6 ratio2 eight ones",      2'd2, 1'b0, 16'h00FF, 5'd16, 1'b0);
        rate_case("R2 R6 ratio1.5 twelve ones",   2'd1, 1'b0, 16'h0FFF, 5'd16, 1'b0);
        rate_case("R1 R6 ratio4 fifteen ones",    2'd3, 1'b0, 16'h7FFF, 5'd16, 1'b0);
        rate_case("R3 length5 upper junk",        2'd0, 1'b0, 16'hA016, 5'd5,  1'b0);
        rate_case("R4 length0 as 16",             2'd0, 1'b0, 16'h8001, 5'd0,  1'b0);
        rate_case("R9 empty waveform",            2'd2, 1'b0, 16'h0000, 5'd16, 1'b0);
        rate_case("R7 divider bypass",            2'd3, 1'b1, 16'h00FF, 5'd16, 1'b0);
        rate_case("R8 squasher bypass",           2'd2, 1'b0, 16'h0001, 5'd16, 1'b1);
        test_mid_reset();
        test_latch_at_wrap();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule